// File: doc/BRIEF.md
# Tiled Multi-Channel Multiply-Accumulate Array

This block is the shared compute engine of a layer accelerator. A single fixed array of TN x TM multipliers performs every convolution layer of a network. It also performs the classifier layers, whose matrix-vector products have been recast as convolutions. On a start pulse it latches a layer descriptor: output tile height and width, kernel height and width, stride, and the number of input-channel tiles. It then walks the channel tiles, the output pixels and the kernel window, issuing one input-buffer read and one weight-buffer read per cycle. Each cycle it consumes TN input-channel samples and a TN x TM weight block.

The block keeps partial sums in an internal tile buffer at 40-bit width. It uses a read-modify-write per output pixel and forwards a value that is written and read back in the same cycle. On the last channel tile it saturates each of the TM lanes to 16 bits and emits one result per output pixel. Loop bounds come from the runtime descriptor, so the same array serves any layer that fits in the tile buffers.

Top module: `tile_mac_array`

## Requirements
- R1: While reset is held, and in the first cycle after it, `busy`, `done`, `res_valid` and `in_rd` are 0.
- R2: For channel tile ct, output pixel (oy,ox) and kernel tap (ky,kx), `in_addr` = ct*TR*TC + (oy*S+ky)*TC + (ox*S+kx). `in_data` is returned one cycle after `in_addr`, and input lane n occupies bits [16n+15:16n].
- R3: `w_addr` = (ct*KMAX+ky)*KMAX+kx, and the weight for output lane m and input lane n occupies bits [16(m*TN+n)+15:16(m*TN+n)] of `w_data`.
- R4: Output lane m of pixel (oy,ox) is the signed sum, over all channel tiles, taps and input lanes, of input times weight, saturated to 16 bits.
- R5: The first channel tile of a layer starts its sums from zero, so partial sums left by an earlier layer have no effect on the results.
- R6: Sums are held at 40 bits and saturated only at final writeback, so an intermediate overflow that later tiles cancel still gives the exact result. The final clamp is to [-32768, 32767].
- R7: Exactly one `res_valid` pulse is produced per output pixel, in raster order, with `res_addr` = oy*TC+ox.
- R8: `done` is high for exactly one cycle, on the clock edge N+3 after the edge that accepted start, where N = nct*rows*cols*kr*kc. `busy` is low from that cycle on.
- R9: The descriptor is captured on the accepted start. Start pulses and descriptor changes while `busy` is high have no effect on the results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a layer (ignored while busy) |
| cfg_rows | input | RW | Output tile rows (1..TR) |
| cfg_cols | input | CW | Output tile columns (1..TC) |
| cfg_kr | input | KW | Kernel rows (1..KMAX) |
| cfg_kc | input | KW | Kernel columns (1..KMAX) |
| cfg_stride | input | SW | Kernel stride (1..SMAX) |
| cfg_nct | input | NW | Input-channel tiles (1..NCT_MAX) |
| in_rd | output | 1 | Input and weight read strobe |
| in_addr | output | IN_AW | Input tile buffer address |
| in_data | input | TN*16 | Input samples, one cycle after address |
| w_addr | output | W_AW | Weight buffer address |
| w_data | input | TN*TM*16 | Weight block, one cycle after address |
| res_valid | output | 1 | Final result strobe |
| res_addr | output | PIX_AW | Output pixel index |
| res_data | output | TM*16 | Saturated output lanes |
| busy | output | 1 | Layer in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions rely on a legal descriptor. All fields are non-zero, and the kernel window stays inside the input tile: (rows-1)*stride+kr <= TR, and likewise for columns. Under that assumption every read address falls inside the buffers. The random stimulus first draws kernel size and stride, then draws the output extent only from the range that this bound allows. The directed cases keep to the same rule.

// File: rtl/tma_pkg.sv
package tma_pkg;
  typedef struct packed {
    logic first_k;
    logic last_k;
    logic first_ct;
    logic last_ct;
    logic last_all;
  } step_flags_t;
endpackage

// File: rtl/tma_seq.sv
module tma_seq
  import tma_pkg::*;
#(
  parameter int TR      = 6,
  parameter int TC      = 6,
  parameter int KMAX    = 3,
  parameter int SMAX    = 2,
  parameter int NCT_MAX = 4,
  localparam int RW     = $clog2(TR + 1),
  localparam int CW     = $clog2(TC + 1),
  localparam int KW     = $clog2(KMAX + 1),
  localparam int SW     = $clog2(SMAX + 1),
  localparam int NW     = $clog2(NCT_MAX + 1),
  localparam int IN_AW  = $clog2(NCT_MAX * TR * TC),
  localparam int W_AW   = $clog2(NCT_MAX * KMAX * KMAX),
  localparam int PIX_AW = $clog2(TR * TC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              layer_busy,
  input  logic [RW-1:0]     cfg_rows,
  input  logic [CW-1:0]     cfg_cols,
  input  logic [KW-1:0]     cfg_kr,
  input  logic [KW-1:0]     cfg_kc,
  input  logic [SW-1:0]     cfg_stride,
  input  logic [NW-1:0]     cfg_nct,
  output logic              in_rd,
  output logic [IN_AW-1:0]  in_addr,
  output logic [W_AW-1:0]   w_addr,
  output logic [PIX_AW-1:0] pix,
  output step_flags_t       flags
);
  logic              run;
  logic [RW-1:0]     q_rows, oy;
  logic [CW-1:0]     q_cols, ox;
  logic [KW-1:0]     q_kr, q_kc, ky, kx;
  logic [SW-1:0]     q_stride;
  logic [NW-1:0]     q_nct, ct;
  logic              kx_end, ky_end, ox_end, oy_end, ct_end;
  logic [IN_AW-1:0]  iy, ix, in_addr_d;
  logic [W_AW-1:0]   w_addr_d;
  logic [PIX_AW-1:0] pix_d;

  assign kx_end = (kx == q_kc - KW'(1));
  assign ky_end = (ky == q_kr - KW'(1));
  assign ox_end = (ox == q_cols - CW'(1));
  assign oy_end = (oy == q_rows - RW'(1));
  assign ct_end = (ct == q_nct - NW'(1));

  always_comb begin
    iy        = IN_AW'(oy) * IN_AW'(q_stride) + IN_AW'(ky);
    ix        = IN_AW'(ox) * IN_AW'(q_stride) + IN_AW'(kx);
    in_addr_d = IN_AW'(ct) * IN_AW'(TR * TC) + iy * IN_AW'(TC) + ix;
    w_addr_d  = (W_AW'(ct) * W_AW'(KMAX) + W_AW'(ky)) * W_AW'(KMAX) + W_AW'(kx);
    pix_d     = PIX_AW'(oy) * PIX_AW'(TC) + PIX_AW'(ox);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run      <= 1'b0;
      in_rd    <= 1'b0;
      in_addr  <= '0;
      w_addr   <= '0;
      pix      <= '0;
      flags    <= '0;
      {q_rows, q_cols, q_kr, q_kc, q_stride, q_nct} <= '0;
      {oy, ox, ky, kx, ct} <= '0;
    end else begin
      in_rd <= run;
      if (run) begin
        in_addr        <= in_addr_d;
        w_addr         <= w_addr_d;
        pix            <= pix_d;
        flags.first_k  <= (kx == '0) && (ky == '0);
        flags.last_k   <= kx_end && ky_end;
        flags.first_ct <= (ct == '0);
        flags.last_ct  <= ct_end;
        flags.last_all <= kx_end && ky_end && ox_end && oy_end && ct_end;
        if (!kx_end) kx <= kx + KW'(1);
        else begin
          kx <= '0;
          if (!ky_end) ky <= ky + KW'(1);
          else begin
            ky <= '0;
            if (!ox_end) ox <= ox + CW'(1);
            else begin
              ox <= '0;
              if (!oy_end) oy <= oy + RW'(1);
              else begin
                oy <= '0;
                if (!ct_end) ct <= ct + NW'(1);
                else begin
                  ct  <= '0;
                  run <= 1'b0;
                end
              end
            end
          end
        end
      end else if (start && !layer_busy) begin
        run      <= 1'b1;
        q_rows   <= cfg_rows;
        q_cols   <= cfg_cols;
        q_kr     <= cfg_kr;
        q_kc     <= cfg_kc;
        q_stride <= cfg_stride;
        q_nct    <= cfg_nct;
        {oy, ox, ky, kx, ct} <= '0;
      end
    end
  end

  // R2: with a legal descriptor every issued read stays inside the input buffer
  a_r2_in_addr_range: assert property (@(posedge clk) disable iff (rst)
    in_rd |-> (int'(in_addr) < NCT_MAX * TR * TC));

  // R9: the latched descriptor does not move while a layer runs
  a_r9_desc_held: assert property (@(posedge clk) disable iff (rst)
    run |=> $stable({q_rows, q_cols, q_kr, q_kc, q_stride, q_nct}));
endmodule

// File: rtl/tma_tree.sv
module tma_tree #(
  parameter int TN    = 4,
  parameter int TM    = 4,
  parameter int DW    = 16,
  parameter int ACC_W = 40
) (
  input  logic [TN*DW-1:0]    in_data,
  input  logic [TN*TM*DW-1:0] w_data,
  output logic [TM*ACC_W-1:0] sums
);
  localparam int PW = 2 * DW;

  for (genvar m = 0; m < TM; m++) begin : g_lane
    always_comb begin
      logic signed [ACC_W-1:0] s;
      logic signed [PW-1:0]    xa, xb, p;
      s = '0;
      for (int n = 0; n < TN; n++) begin
        xa = PW'($signed(in_data[n*DW +: DW]));
        xb = PW'($signed(w_data[(m*TN+n)*DW +: DW]));
        p  = xa * xb;
        s  = s + ACC_W'(p);
      end
      sums[m*ACC_W +: ACC_W] = s;
    end
  end
endmodule

// File: rtl/tma_psum.sv
module tma_psum #(
  parameter int DEPTH = 36,
  parameter int W     = 160,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] wa,
  input  logic [W-1:0]  wd,
  input  logic [AW-1:0] ra,
  output logic [W-1:0]  rd
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wa] <= wd;
    rd <= (we && (wa == ra)) ? wd : mem[ra];
  end
endmodule

// File: rtl/tile_mac_array.sv
module tile_mac_array
  import tma_pkg::*;
#(
  parameter int TN      = 4,
  parameter int TM      = 4,
  parameter int DW      = 16,
  parameter int ACC_W   = 40,
  parameter int TR      = 6,
  parameter int TC      = 6,
  parameter int KMAX    = 3,
  parameter int SMAX    = 2,
  parameter int NCT_MAX = 4,
  localparam int RW     = $clog2(TR + 1),
  localparam int CW     = $clog2(TC + 1),
  localparam int KW     = $clog2(KMAX + 1),
  localparam int SW     = $clog2(SMAX + 1),
  localparam int NW     = $clog2(NCT_MAX + 1),
  localparam int IN_AW  = $clog2(NCT_MAX * TR * TC),
  localparam int W_AW   = $clog2(NCT_MAX * KMAX * KMAX),
  localparam int PIX_AW = $clog2(TR * TC)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [RW-1:0]       cfg_rows,
  input  logic [CW-1:0]       cfg_cols,
  input  logic [KW-1:0]       cfg_kr,
  input  logic [KW-1:0]       cfg_kc,
  input  logic [SW-1:0]       cfg_stride,
  input  logic [NW-1:0]       cfg_nct,
  output logic                in_rd,
  output logic [IN_AW-1:0]    in_addr,
  input  logic [TN*DW-1:0]    in_data,
  output logic [W_AW-1:0]     w_addr,
  input  logic [TN*TM*DW-1:0] w_data,
  output logic                res_valid,
  output logic [PIX_AW-1:0]   res_addr,
  output logic [TM*DW-1:0]    res_data,
  output logic                busy,
  output logic                done
);
  localparam logic signed [ACC_W-1:0] SAT_HI = ACC_W'(2 ** (DW - 1) - 1);
  localparam logic signed [ACC_W-1:0] SAT_LO = -SAT_HI - ACC_W'(1);

  logic [PIX_AW-1:0]   p1_pix, p2_pix;
  step_flags_t         p1_flags, p2_flags;
  logic                p2_v, wb_en, done_arm;
  logic [TM*ACC_W-1:0] tree_sum, psum_rd, acc, win_all, tot_all;
  logic [TM*DW-1:0]    sat_all;

  tma_seq #(.TR(TR), .TC(TC), .KMAX(KMAX), .SMAX(SMAX), .NCT_MAX(NCT_MAX)) u_seq (
    .clk(clk), .rst(rst), .start(start), .layer_busy(busy),
    .cfg_rows(cfg_rows), .cfg_cols(cfg_cols), .cfg_kr(cfg_kr), .cfg_kc(cfg_kc),
    .cfg_stride(cfg_stride), .cfg_nct(cfg_nct),
    .in_rd(in_rd), .in_addr(in_addr), .w_addr(w_addr), .pix(p1_pix), .flags(p1_flags)
  );

  tma_tree #(.TN(TN), .TM(TM), .DW(DW), .ACC_W(ACC_W)) u_tree (
    .in_data(in_data), .w_data(w_data), .sums(tree_sum)
  );

  assign wb_en = p2_v && p2_flags.last_k;

  tma_psum #(.DEPTH(TR * TC), .W(TM * ACC_W)) u_psum (
    .clk(clk), .we(wb_en), .wa(p2_pix), .wd(tot_all), .ra(p1_pix), .rd(psum_rd)
  );

  for (genvar m = 0; m < TM; m++) begin : g_lane
    logic signed [ACC_W-1:0] t_s, a_s, p_s, w_s, o_s;
    assign t_s = $signed(tree_sum[m*ACC_W +: ACC_W]);
    assign a_s = $signed(acc[m*ACC_W +: ACC_W]);
    assign p_s = $signed(psum_rd[m*ACC_W +: ACC_W]);
    assign w_s = (p2_flags.first_k ? '0 : a_s) + t_s;
    assign o_s = w_s + (p2_flags.first_ct ? '0 : p_s);
    assign win_all[m*ACC_W +: ACC_W] = w_s;
    assign tot_all[m*ACC_W +: ACC_W] = o_s;
    assign sat_all[m*DW +: DW] = (o_s > SAT_HI) ? DW'(SAT_HI) :
                                 (o_s < SAT_LO) ? DW'(SAT_LO) : o_s[DW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      p2_v      <= 1'b0;
      p2_pix    <= '0;
      p2_flags  <= '0;
      acc       <= '0;
      res_valid <= 1'b0;
      res_addr  <= '0;
      res_data  <= '0;
      done_arm  <= 1'b0;
      done      <= 1'b0;
      busy      <= 1'b0;
    end else begin
      p2_v     <= in_rd;
      p2_pix   <= p1_pix;
      p2_flags <= p1_flags;
      if (p2_v) acc <= win_all;
      res_valid <= wb_en && p2_flags.last_ct;
      if (wb_en && p2_flags.last_ct) begin
        res_addr <= p2_pix;
        res_data <= sat_all;
      end
      done_arm <= wb_en && p2_flags.last_all;
      done     <= done_arm;
      if (start && !busy) busy <= 1'b1;
      else if (done_arm)  busy <= 1'b0;
    end
  end

  // R8: completion is a single-cycle pulse
  a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R8: completion follows the final result by one cycle
  a_r8_done_after_result: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(res_valid));
  // R7: results only appear inside a running layer
  a_r7_result_in_layer: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> busy);
  // R7: result pixel index lies inside the tile
  a_r7_res_addr_range: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> (int'(res_addr) < TR * TC));
endmodule

// File: tb/tile_mac_array_bench.sv
`timescale 1ns/1ps
module tile_mac_array_bench;
  localparam int TN = 4, TM = 4, DW = 16, TR = 6, TC = 6, KMAX = 3, SMAX = 2, NCT_MAX = 4;
  localparam int IN_DEPTH = NCT_MAX * TR * TC;
  localparam int W_DEPTH  = NCT_MAX * KMAX * KMAX;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [2:0] cfg_rows = '0, cfg_cols = '0, cfg_nct = '0;
  logic [1:0] cfg_kr = '0, cfg_kc = '0, cfg_stride = '0;
  logic in_rd, res_valid, busy, done;
  logic [7:0] in_addr;
  logic [5:0] w_addr, res_addr;
  logic [TN*DW-1:0] in_data = '0;
  logic [TN*TM*DW-1:0] w_data = '0;
  logic [TM*DW-1:0] res_data;

  logic [TN*DW-1:0]    in_mem [IN_DEPTH];
  logic [TN*TM*DW-1:0] w_mem  [W_DEPTH];

  int n_chk = 0, n_fail = 0;
  int L_r, L_c, L_kr, L_kc, L_s, L_n;
  int e_oy, e_ox, npix;
  string cur_tag = "R4";

  tile_mac_array u_tile_mac_array (
    .clk(clk), .rst(rst), .start(start),
    .cfg_rows(cfg_rows), .cfg_cols(cfg_cols), .cfg_kr(cfg_kr), .cfg_kc(cfg_kc),
    .cfg_stride(cfg_stride), .cfg_nct(cfg_nct),
    .in_rd(in_rd), .in_addr(in_addr), .in_data(in_data),
    .w_addr(w_addr), .w_data(w_data),
    .res_valid(res_valid), .res_addr(res_addr), .res_data(res_data),
    .busy(busy), .done(done)
  );

  always #2 clk = ~clk;

  // buffer model: one-cycle read latency (R2, R3)
  always @(posedge clk) begin
    in_data <= in_mem[in_addr];
    w_data  <= w_mem[w_addr];
  end

  task automatic check(string tag, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic longint sat16(longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  function automatic longint exp_sum(int oy, int ox, int m);
    longint s = 0;
    for (int ct = 0; ct < L_n; ct++)
      for (int ky = 0; ky < L_kr; ky++)
        for (int kx = 0; kx < L_kc; kx++) begin
          int ia = ct*TR*TC + (oy*L_s+ky)*TC + (ox*L_s+kx);
          int wa = (ct*KMAX+ky)*KMAX + kx;
          for (int n = 0; n < TN; n++)
            s += longint'($signed(in_mem[ia][n*DW +: DW])) *
                 longint'($signed(w_mem[wa][(m*TN+n)*DW +: DW]));
        end
    return s;
  endfunction

  always @(negedge clk) begin
    if (!rst && res_valid) begin
      check("R7 pixel order", longint'(res_addr), longint'(e_oy*TC + e_ox));
      for (int m = 0; m < TM; m++)
        check(cur_tag, longint'($signed(res_data[m*DW +: DW])), sat16(exp_sum(e_oy, e_ox, m)));
      npix++;
      if (e_ox == L_c - 1) begin e_ox = 0; e_oy++; end else e_ox++;
    end
  end

  task automatic fill_rand(int amp);
    for (int i = 0; i < IN_DEPTH; i++)
      for (int n = 0; n < TN; n++)
        in_mem[i][n*DW +: DW] = DW'(int'($urandom_range(2*amp)) - amp);
    for (int i = 0; i < W_DEPTH; i++)
      for (int k = 0; k < TN*TM; k++)
        w_mem[i][k*DW +: DW] = DW'(int'($urandom_range(2*amp)) - amp);
  endtask

  task automatic fill_const(int iv, int w0, int w1);
    for (int i = 0; i < IN_DEPTH; i++)
      for (int n = 0; n < TN; n++) in_mem[i][n*DW +: DW] = DW'(iv);
    for (int i = 0; i < W_DEPTH; i++)
      for (int k = 0; k < TN*TM; k++)
        w_mem[i][k*DW +: DW] = DW'((i < KMAX*KMAX) ? w0 : w1);
  endtask

  task automatic run_layer(int r, int c, int kr, int kc, int s, int nct, string tag, bit scramble);
    int cyc = 0;
    L_r = r; L_c = c; L_kr = kr; L_kc = kc; L_s = s; L_n = nct;
    e_oy = 0; e_ox = 0; npix = 0; cur_tag = tag;
    @(negedge clk);
    cfg_rows = 3'(r); cfg_cols = 3'(c); cfg_kr = 2'(kr); cfg_kc = 2'(kc);
    cfg_stride = 2'(s); cfg_nct = 3'(nct); start = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    while (cyc < 5000) begin
      @(posedge clk);
      cyc++;
      @(negedge clk);
      if (scramble && cyc < 6) begin   // R9: disturb descriptor while busy
        start = 1'b1;
        cfg_rows = 3'($urandom_range(1, 6)); cfg_cols = 3'($urandom_range(1, 6));
        cfg_kr = 2'($urandom_range(1, 3)); cfg_nct = 3'($urandom_range(1, 4));
      end else start = 1'b0;
      if (done) break;
    end
    check("R8 start-to-done cycles", cyc, r*c*kr*kc*nct + 3);
    check("R7 result count", npix, r*c);
    check("R8 busy low with done", longint'(busy), 0);
    @(posedge clk);
    @(negedge clk);
    check("R8 done single pulse", longint'(done), 0);
  endtask

  initial begin
    #(4 * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    fill_rand(100);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R1 busy", longint'(busy), 0);
    check("R1 done", longint'(done), 0);
    check("R1 res_valid", longint'(res_valid), 0);
    check("R1 in_rd", longint'(in_rd), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 busy after release", longint'(busy), 0);
    check("R1 res_valid after release", longint'(res_valid), 0);

    // minimal layer, then repeated same pixel across channel tiles (forwarding)
    run_layer(1, 1, 1, 1, 1, 1, "R4 minimal", 1'b0);
    run_layer(1, 1, 1, 1, 1, 4, "R4 back-to-back tiles", 1'b0);
    run_layer(6, 6, 1, 1, 1, 2, "R2 R3 full tile", 1'b0);
    run_layer(2, 2, 3, 3, 2, 3, "R2 R3 stride two", 1'b0);

    // R5: stale partial sums from a deeper layer must not leak
    run_layer(3, 3, 2, 2, 1, 3, "R5 priming layer", 1'b0);
    run_layer(3, 3, 2, 2, 1, 1, "R5 fresh start", 1'b0);

    // R6: saturation and wide intermediate sums
    fill_const(32767, 32767, 32767);
    run_layer(2, 2, 3, 3, 1, 1, "R6 clamp high", 1'b0);
    fill_const(32767, -32767, -32767);
    run_layer(2, 2, 3, 3, 1, 1, "R6 clamp low", 1'b0);
    fill_const(32767, 32767, -32767);
    run_layer(2, 2, 3, 3, 1, 2, "R6 cancel to exact", 1'b0);

    // R9: start and descriptor changes while busy are ignored
    fill_rand(100);
    run_layer(3, 3, 2, 2, 1, 2, "R9 descriptor held", 1'b1);

    for (int t = 0; t < 20; t++) begin
      int kr = $urandom_range(1, 3);
      int kc = $urandom_range(1, 3);
      int s  = $urandom_range(1, 2);
      int r  = $urandom_range(1, (TR - kr) / s + 1);
      int c  = $urandom_range(1, (TC - kc) / s + 1);
      int n  = $urandom_range(1, 4);
      if (t % 5 == 0) fill_rand(3000); else if (t % 5 == 1) fill_rand(100);
      run_layer(r, c, kr, kc, s, n, "R4 random (R2 R3 addressing)", 1'b0);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule